// File: doc/BRIEF.md
# Power-Management Interrupt Event Collector

This block gathers power-management and platform wake events and turns them into two interrupt outputs for the processor side of a chip. One is an active-low system-management interrupt line. The other is a level-held system-control interrupt that is steered onto one of seven interrupt request lines. Every cause has a sticky status flag. A one-cycle event pulse sets the flag, and writing a 1 to it clears it. Each cause has a separate enable for each of the two interrupt paths. A small write/read register port holds the status, the enables, the control word, the general-purpose input routing and the watchdog interrupt-type field. The block also contains a free-running power-management timer. An edge of the timer's top bit is itself one of the causes.

Software enables the causes it handles. When an event arrives, software services the resulting interrupt and clears the status bits. For the management interrupt it then writes the end-of-service bit. The management line only releases on that write. After release it stays high for a guaranteed number of clock cycles before it may fall again. The control interrupt is a level: it falls only after every enabled contributing status bit has been cleared.

Top module: `pm_irq_agg`

## Requirements
- R1: After synchronous reset, every status, enable, route and type field reads 0, the control word reads 7'b0000010 (only the end-of-service flag set), `smi_n` is 1 and `irq_o` is all zero.
- R2: Cause status bits live at address 0. Bit k is set by `ev_pulse[k-1]` for k=1..11, and bit 0 is set by the timer. Each bit is cleared by writing 1 to it. A pulse and a clearing write on the same bit in the same cycle leave the bit set. A status bit reads back 1 at the first read after the pulse edge.
- R3: A status bit whose management enable is set (address 2, same bit positions) pulls `smi_n` low one cycle after the status rises. `smi_n` stays low even after every status is cleared, until bit 1 of the control word (address 3) is written with 1.
- R4: After that end-of-service write, `smi_n` stays high for exactly MIN_GAP cycles. If a request is still pending, it falls again after those cycles. With no request, it stays high.
- R5: The control interrupt is active only while control-word bit 0 (global enable) is 1 and at least one status bit with its control enable set (address 1) is 1. It drops one cycle after the last such bit is cleared.
- R6: Control-word bits 5:3 hold the route code. In all modes, codes 0, 1 and 2 select IRQ 9, 10 and 11 on `irq_o[0..2]`. With control bit 2 (extended mode) set, codes 3 to 6 select IRQ 20 to 23 on `irq_o[3..6]`. Any other code drives every output to 0. The outputs follow a route or level change after one cycle.
- R7: With control bit 6 (shared line) set, the selected legal line is active-low: it is 1 when idle and 0 while the interrupt is active. Unselected lines stay 0.
- R8: General-purpose input i has a status bit i at address 6, set by `gpi_pulse[i]` and cleared by writing 1. It has an enable bit i at address 5 and a 2-bit route field at address 4 bits [2i+1:2i]. Route 2'b10 feeds the control interrupt, 2'b01 feeds the management interrupt, and 2'b00 or 2'b11 feeds neither.
- R9: The watchdog cause (status bit 11) contributes according to its type field at address 7 bits [1:0]. Value 2'b01 lets it reach only the control interrupt, 2'b10 only the management interrupt, and other values neither.
- R10: The timer counts once every TICK_DIV cycles and reads back at address 8. Status bit 0 is set on both the rising and the falling edge of the counter's top bit, and at no other count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_pulse | input | 11 | One-cycle event pulses for status bits 1 to 11 |
| gpi_pulse | input | N_GPI | One-cycle general-purpose input event pulses |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data, combinational on `addr` |
| smi_n | output | 1 | Active-low management interrupt |
| irq_o | output | 7 | Control interrupt lines IRQ 9, 10, 11, 20, 21, 22, 23 |

## Verification
Two pairs of functions can fall in the same clock edge. In the first, an event pulse and a write-one-to-clear hit the same status bit. The bench raises `ev_pulse` and the clearing write in a single cycle and expects the bit to read back set, and then cleared after a lone write. In the second, the end-of-service write meets a request that is still pending. The bench leaves the status set while writing the end-of-service bit, checks `smi_n` high on each of the MIN_GAP following cycles, and expects it low on the cycle after that.

// File: rtl/pm_evt_pkg.sv
// Shared constants and types for the power-management interrupt collector.
// Assumes a 16-bit register port and seven interrupt request lines.
package pm_evt_pkg;

    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 4;
    localparam int N_CAUSE  = 12;
    localparam int N_EXT    = N_CAUSE - 1;
    localparam int N_IRQ    = 7;
    localparam int N_LEGACY = 3;

    // Cause positions inside the status word
    localparam int C_TMR = 0;
    localparam int C_WDT = 11;

    typedef enum logic [ADDR_W-1:0] {
        A_STS      = 4'd0,
        A_SCI_EN   = 4'd1,
        A_SMI_EN   = 4'd2,
        A_CTRL     = 4'd3,
        A_GPI_RT   = 4'd4,
        A_GPI_EN   = 4'd5,
        A_GPI_STS  = 4'd6,
        A_WDT_TYPE = 4'd7,
        A_TMR      = 4'd8
    } reg_addr_e;

    localparam logic [1:0] GPI_TO_SMI = 2'b01;
    localparam logic [1:0] GPI_TO_SCI = 2'b10;
    localparam logic [1:0] WDT_TO_SCI = 2'b01;
    localparam logic [1:0] WDT_TO_SMI = 2'b10;

    // Control word: shared[6] route[5:3] apic[2] eos[1] glb[0]
    typedef struct packed {
        logic       shared;
        logic [2:0] route;
        logic       apic;
        logic       eos;
        logic       glb;
    } ctrl_t;

endpackage

// File: rtl/pm_sticky_bank.sv
// Bank of sticky status flags: a set pulse raises a flag, a clear strobe
// lowers it, and set wins when both arrive in one cycle.
// Assumes set and clear are synchronous to clk.
module pm_sticky_bank #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    // One flag per bit; set has priority over clear
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[i] <= 1'b0;
            else if (set_i[i])
                q_o[i] <= 1'b1;
            else if (clr_i[i])
                q_o[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]); // R2
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[i] && !clr_i[i]) |=> (q_o[i] == $past(q_o[i]))); // R2
    end

endmodule

// File: rtl/pm_acpi_timer.sv
// Free-running power-management timer. It advances once every TICK_DIV
// clocks and flags an overflow pulse in the cycle that toggles its top bit.
// Assumes CNT_W >= 2 and TICK_DIV >= 1.
module pm_acpi_timer #(
    parameter int CNT_W    = 24,
    parameter int TICK_DIV = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    localparam int              PRE_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic             tick;

    assign tick  = (pre_q == PRE_LAST);
    assign ovf_o = tick && (&cnt_o[CNT_W-2:0]);

    // Prescaler producing one tick every TICK_DIV clocks
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    // Counter advancing on each tick, wrapping freely
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (tick)
            cnt_o <= cnt_o + 1'b1;
    end

    AST_TMR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_o)); // R10
    AST_TMR_OVF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_o[CNT_W-1] != $past(cnt_o[CNT_W-1]))); // R10

endmodule

// File: rtl/pm_smi_gate.sv
// Management interrupt latch. A pending request asserts the line when the
// end-of-service flag is set and the release gap has run out. Only an
// end-of-service write releases the line, and that write starts a gap of
// MIN_GAP cycles with the line high.
// Assumes eos_wr_i is a single-cycle strobe from the register port.
module pm_smi_gate #(
    parameter int MIN_GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic eos_wr_i,
    output logic smi_n_o,
    output logic eos_o
);

    localparam int               GAP_W    = $clog2(MIN_GAP + 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MIN_GAP - 1);
    localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(MIN_GAP);

    logic             act_q;
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] idle_q;

    assign smi_n_o = ~act_q;

    // Latch, release and gap sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            eos_o <= 1'b1;
            gap_q <= '0;
        end else if (act_q && eos_wr_i) begin
            act_q <= 1'b0;
            eos_o <= 1'b1;
            gap_q <= GAP_LOAD;
        end else if (!act_q && eos_o && gap_q == '0 && req_i) begin
            act_q <= 1'b1;
            eos_o <= 1'b0;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    // Independent count of high cycles, used only by the gap assertion
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_q <= GAP_FULL;
        else if (act_q)
            idle_q <= '0;
        else if (idle_q != GAP_FULL)
            idle_q <= idle_q + 1'b1;
    end

    AST_SMI_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smi_n_o) |-> (idle_q >= GAP_FULL)); // R4
    AST_SMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!smi_n_o && !eos_wr_i) |=> !smi_n_o); // R3
    AST_SMI_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_n_o && !req_i) |=> smi_n_o); // R3

endmodule

// File: rtl/pm_sci_router.sv
// Control interrupt router. It registers the level onto the line picked by
// the route code, drops routes that are illegal for the current mode, and
// inverts a line that is marked shared.
// Assumes N_IRQ lines, the first N_LEGACY of them legal in every mode.
module pm_sci_router #(
    parameter int N_IRQ    = 7,
    parameter int N_LEGACY = 3,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sci_i,
    input  logic             apic_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             shared_i,
    output logic [N_IRQ-1:0] irq_o
);

    logic             legal;
    logic [N_IRQ-1:0] lvl_q;
    logic [N_IRQ-1:0] pol_q;

    // Route code legality depends on the interrupt mode
    always_comb begin
        legal = (int'(sel_i) < N_LEGACY) || (apic_i && int'(sel_i) < N_IRQ);
    end

    // Registered level and polarity per output line
    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[i] <= 1'b0;
                pol_q[i] <= 1'b0;
            end else begin
                lvl_q[i] <= legal && (int'(sel_i) == i) && sci_i;
                pol_q[i] <= legal && (int'(sel_i) == i) && shared_i;
            end
        end
    end

    assign irq_o = lvl_q ^ pol_q;

    AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lvl_q)); // R6
    AST_ILLEGAL_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!apic_i && int'(sel_i) >= N_LEGACY) |=> (irq_o == '0)); // R6

endmodule

// File: rtl/pm_irq_agg.sv
// Power-management interrupt collector top. Holds the register file, the
// cause and GPI status banks and the enable masks. It combines them into a
// management request and a control interrupt level, and drives both outputs.
// Assumes N_GPI <= 8 so the route field fits the 16-bit data word.
module pm_irq_agg #(
    parameter int N_GPI    = 4,
    parameter int TMR_W    = 24,
    parameter int TICK_DIV = 28,
    parameter int MIN_GAP  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [pm_evt_pkg::N_EXT-1:0] ev_pulse,
    input  logic [N_GPI-1:0]             gpi_pulse,
    input  logic                         wr_en,
    input  logic [pm_evt_pkg::ADDR_W-1:0] addr,
    input  logic [pm_evt_pkg::DATA_W-1:0] wdata,
    output logic [pm_evt_pkg::DATA_W-1:0] rdata,
    output logic                         smi_n,
    output logic [pm_evt_pkg::N_IRQ-1:0] irq_o
);
    import pm_evt_pkg::*;

    localparam int RT_W = 2 * N_GPI;

    ctrl_t              ctrl_q;
    logic               eos_flag;
    logic [N_CAUSE-1:0] sts, sci_en_q, smi_en_q, sts_clr, sci_mask, smi_mask;
    logic [N_GPI-1:0]   gpi_sts, gpi_en_q, gpi_clr, gpi_sci_sel, gpi_smi_sel;
    logic [RT_W-1:0]    gpi_rt_q;
    logic [1:0]         wdt_type_q;
    logic [TMR_W-1:0]   tmr_cnt;
    logic               tmr_ovf, eos_wr, sci_lvl, smi_req;
    logic               unused_wdata;

    assign unused_wdata = ^wdata;

    // Write strobes for the register file
    function automatic logic hit(input reg_addr_e a);
        return wr_en && (addr == a);
    endfunction

    assign sts_clr = hit(A_STS)     ? wdata[N_CAUSE-1:0] : '0;
    assign gpi_clr = hit(A_GPI_STS) ? wdata[N_GPI-1:0]   : '0;
    assign eos_wr  = hit(A_CTRL) && wdata[1];

    pm_acpi_timer #(.CNT_W(TMR_W), .TICK_DIV(TICK_DIV)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (tmr_cnt),
        .ovf_o (tmr_ovf)
    );

    pm_sticky_bank #(.W(N_CAUSE)) u_cause_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i ({ev_pulse, tmr_ovf}),
        .clr_i (sts_clr),
        .q_o   (sts)
    );

    pm_sticky_bank #(.W(N_GPI)) u_gpi_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (gpi_pulse),
        .clr_i (gpi_clr),
        .q_o   (gpi_sts)
    );

    // Software-owned enable, route and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sci_en_q   <= '0;
            smi_en_q   <= '0;
            gpi_en_q   <= '0;
            gpi_rt_q   <= '0;
            wdt_type_q <= '0;
            ctrl_q     <= '0;
        end else begin
            if (hit(A_SCI_EN))   sci_en_q   <= wdata[N_CAUSE-1:0];
            if (hit(A_SMI_EN))   smi_en_q   <= wdata[N_CAUSE-1:0];
            if (hit(A_GPI_EN))   gpi_en_q   <= wdata[N_GPI-1:0];
            if (hit(A_GPI_RT))   gpi_rt_q   <= wdata[RT_W-1:0];
            if (hit(A_WDT_TYPE)) wdt_type_q <= wdata[1:0];
            if (hit(A_CTRL)) begin
                ctrl_q.glb    <= wdata[0];
                ctrl_q.apic   <= wdata[2];
                ctrl_q.route  <= wdata[5:3];
                ctrl_q.shared <= wdata[6];
            end
        end
    end

    // Per-GPI route decode
    for (genvar i = 0; i < N_GPI; i++) begin : g_gpi
        assign gpi_sci_sel[i] = (gpi_rt_q[2*i +: 2] == GPI_TO_SCI);
        assign gpi_smi_sel[i] = (gpi_rt_q[2*i +: 2] == GPI_TO_SMI);
    end

    // Path masks: only the watchdog cause depends on its type field
    always_comb begin
        sci_mask        = '1;
        smi_mask        = '1;
        sci_mask[C_WDT] = (wdt_type_q == WDT_TO_SCI);
        smi_mask[C_WDT] = (wdt_type_q == WDT_TO_SMI);
    end

    // Combined request levels for both interrupt paths
    always_comb begin
        sci_lvl = ctrl_q.glb &&
                  ((|(sts & sci_en_q & sci_mask)) || (|(gpi_sts & gpi_en_q & gpi_sci_sel)));
        smi_req = (|(sts & smi_en_q & smi_mask)) || (|(gpi_sts & gpi_en_q & gpi_smi_sel));
    end

    pm_smi_gate #(.MIN_GAP(MIN_GAP)) u_smi (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (smi_req),
        .eos_wr_i (eos_wr),
        .smi_n_o  (smi_n),
        .eos_o    (eos_flag)
    );

    pm_sci_router #(.N_IRQ(N_IRQ), .N_LEGACY(N_LEGACY), .SEL_W(3)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .sci_i    (sci_lvl),
        .apic_i   (ctrl_q.apic),
        .sel_i    (ctrl_q.route),
        .shared_i (ctrl_q.shared),
        .irq_o    (irq_o)
    );

    // Register read mux
    always_comb begin
        rdata = '0;
        case (addr)
            A_STS:      rdata = DATA_W'(sts);
            A_SCI_EN:   rdata = DATA_W'(sci_en_q);
            A_SMI_EN:   rdata = DATA_W'(smi_en_q);
            A_CTRL:     rdata = DATA_W'({ctrl_q.shared, ctrl_q.route, ctrl_q.apic,
                                         eos_flag, ctrl_q.glb});
            A_GPI_RT:   rdata = DATA_W'(gpi_rt_q);
            A_GPI_EN:   rdata = DATA_W'(gpi_en_q);
            A_GPI_STS:  rdata = DATA_W'(gpi_sts);
            A_WDT_TYPE: rdata = DATA_W'(wdt_type_q);
            A_TMR:      rdata = DATA_W'(tmr_cnt);
            default:    rdata = '0;
        endcase
    end

    AST_SCI_GLB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.glb && !ctrl_q.shared) |=> (irq_o == '0)); // R5
    AST_SCI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & sci_en_q) == '0 && (gpi_sts & gpi_en_q) == '0 && !ctrl_q.shared)
        |=> (irq_o == '0)); // R5

endmodule

// File: tb/pm_irq_agg_bench.sv
`timescale 1ns/1ps
module pm_irq_agg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] ev_pulse = '0;
    logic [3:0]  gpi_pulse = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        smi_n;
    logic [6:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pm_irq_agg #(.N_GPI(4), .TMR_W(8), .TICK_DIV(2), .MIN_GAP(4)) u_pm_irq_agg (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .gpi_pulse(gpi_pulse),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .smi_n(smi_n), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse_ev(input int k);
        @(negedge clk);
        ev_pulse[k] = 1'b1;
        @(negedge clk);
        ev_pulse[k] = 1'b0;
    endtask

    task automatic pulse_gpi(input int k);
        @(negedge clk);
        gpi_pulse[k] = 1'b1;
        @(negedge clk);
        gpi_pulse[k] = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Control word helper: shared[6] route[5:3] apic[2] eos[1] glb[0]
    function automatic logic [15:0] cw(input logic sh, input logic [2:0] rt,
                                       input logic ap, input logic eos, input logic g);
        return {9'd0, sh, rt, ap, eos, g};
    endfunction

    task automatic t_reset();
        logic [15:0] d;
        rd(4'd0, d); chk("R1 status", d & 16'hFFFE, 0);
        rd(4'd1, d); chk("R1 sci enable", d, 0);
        rd(4'd3, d); chk("R1 control", d, 16'h0002);
        rd(4'd4, d); chk("R1 gpi route", d, 0);
        chk("R1 smi_n", smi_n, 1);
        chk("R1 irq", irq_o, 0);
    endtask

    task automatic t_sticky();
        logic [15:0] d;
        pulse_ev(4);                       // status bit 5
        rd(4'd0, d); chk("R2 set by pulse", d[5], 1);
        wait_cyc(3);
        rd(4'd0, d); chk("R2 sticky", d[5], 1);
        @(negedge clk);                    // collision: pulse and clear together
        ev_pulse[4] = 1'b1; wr_en = 1'b1; addr = 4'd0; wdata = 16'h0020;
        @(negedge clk);
        ev_pulse[4] = 1'b0; wr_en = 1'b0;
        rd(4'd0, d); chk("R2 set wins over clear", d[5], 1);
        wr(4'd0, 16'h0020);
        rd(4'd0, d); chk("R2 write one clears", d[5], 0);
    endtask

    task automatic poll_tmr(input logic [7:0] v);
        logic [15:0] d;
        for (int i = 0; i < 1000; i++) begin
            rd(4'd8, d);
            if (d[7:0] == v) return;
            @(negedge clk);
        end
        chk("R10 timer reached value", 0, 1);
    endtask

    task automatic t_timer();
        logic [15:0] d;
        poll_tmr(8'h10);
        wr(4'd0, 16'h0001);
        poll_tmr(8'h7F);
        rd(4'd0, d); chk("R10 no flag before top bit rises", d[0], 0);
        poll_tmr(8'h80);
        rd(4'd0, d); chk("R10 flag on rising top bit", d[0], 1);
        wr(4'd0, 16'h0001);
        poll_tmr(8'hFF);
        rd(4'd0, d); chk("R10 no flag before top bit falls", d[0], 0);
        poll_tmr(8'h00);
        rd(4'd0, d); chk("R10 flag on falling top bit", d[0], 1);
    endtask

    task automatic t_smi_latch();
        wr(4'd2, 16'h0002);                // management enable, power button bit 1
        chk("R3 idle before event", smi_n, 1);
        pulse_ev(0);
        @(negedge clk);
        chk("R3 asserts after event", smi_n, 0);
        wr(4'd0, 16'h0002);
        wait_cyc(3);
        chk("R3 held after status cleared", smi_n, 0);
        wr(4'd3, cw(0, 0, 0, 1, 0));
        chk("R3 released by end-of-service", smi_n, 1);
        wait_cyc(8);
        chk("R3 stays high with no request", smi_n, 1);
    endtask

    task automatic t_smi_gap();
        pulse_ev(0);
        @(negedge clk);
        chk("R4 asserted", smi_n, 0);
        wr(4'd3, cw(0, 0, 0, 1, 0));       // status still pending
        chk("R4 high right after release", smi_n, 1);
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            chk("R4 high during gap", smi_n, 1);
        end
        @(negedge clk);
        chk("R4 reasserts after gap", smi_n, 0);
        wr(4'd0, 16'h0002);
        wr(4'd3, cw(0, 0, 0, 1, 0));
        wr(4'd2, 16'h0000);
        wait_cyc(6);
    endtask

    task automatic t_sci_level();
        wr(4'd1, 16'h000C);                // control enable for bits 2 and 3
        pulse_ev(1);
        wait_cyc(2);
        chk("R5 no interrupt with global enable off", irq_o, 0);
        wr(4'd3, cw(0, 0, 0, 0, 1));
        @(negedge clk);
        chk("R5 active on IRQ9", irq_o, 7'b0000001);
        pulse_ev(2);
        wr(4'd0, 16'h0004);
        @(negedge clk);
        chk("R5 held while a source remains", irq_o, 7'b0000001);
        wr(4'd0, 16'h0008);
        @(negedge clk);
        chk("R5 drops when last source clears", irq_o, 0);
    endtask

    task automatic t_route();
        pulse_ev(2);                       // status bit 3 keeps the level up
        for (int c = 0; c < 8; c++) begin
            wr(4'd3, cw(0, 3'(c), 0, 0, 1));
            @(negedge clk);
            chk("R6 route without extended mode", irq_o,
                (c < 3) ? (7'b1 << c) : 7'b0);
        end
        for (int c = 3; c < 8; c++) begin
            wr(4'd3, cw(0, 3'(c), 1, 0, 1));
            @(negedge clk);
            chk("R6 route with extended mode", irq_o,
                (c < 7) ? (7'b1 << c) : 7'b0);
        end
    endtask

    task automatic t_polarity();
        wr(4'd3, cw(1, 3'd1, 0, 0, 1));
        @(negedge clk);
        chk("R7 shared line low while active", irq_o, 7'b0000000);
        wr(4'd0, 16'h0008);
        @(negedge clk);
        chk("R7 shared line high when idle", irq_o, 7'b0000010);
        wr(4'd3, cw(0, 3'd0, 0, 0, 1));
        @(negedge clk);
    endtask

    task automatic t_gpi();
        logic [15:0] d;
        wr(4'd4, 16'b11_00_01_10);         // gpi3=11 gpi2=00 gpi1=01 gpi0=10
        wr(4'd5, 16'h000F);
        pulse_gpi(2);
        pulse_gpi(3);
        wait_cyc(2);
        rd(4'd6, d); chk("R8 gpi status set", d, 16'h000C);
        chk("R8 route 00 and 11 no control interrupt", irq_o, 0);
        chk("R8 route 00 and 11 no management interrupt", smi_n, 1);
        pulse_gpi(0);
        @(negedge clk);
        chk("R8 route 10 raises control interrupt", irq_o, 7'b0000001);
        chk("R8 route 10 no management interrupt", smi_n, 1);
        wr(4'd6, 16'h000F);
        @(negedge clk);
        chk("R8 cleared", irq_o, 0);
        pulse_gpi(1);
        @(negedge clk);
        chk("R8 route 01 raises management interrupt", smi_n, 0);
        chk("R8 route 01 no control interrupt", irq_o, 0);
        wr(4'd6, 16'h000F);
        wr(4'd3, cw(0, 0, 0, 1, 1));
        wait_cyc(6);
    endtask

    task automatic t_wdt();
        wr(4'd1, 16'h0800);
        wr(4'd2, 16'h0800);
        pulse_ev(10);
        wait_cyc(2);
        chk("R9 type 00 no control interrupt", irq_o, 0);
        chk("R9 type 00 no management interrupt", smi_n, 1);
        wr(4'd7, 16'h0001);
        @(negedge clk);
        chk("R9 type 01 control interrupt", irq_o, 7'b0000001);
        chk("R9 type 01 no management interrupt", smi_n, 1);
        wr(4'd7, 16'h0002);
        @(negedge clk);
        chk("R9 type 10 no control interrupt", irq_o, 0);
        chk("R9 type 10 management interrupt", smi_n, 0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_timer();
        t_smi_latch();
        t_smi_gap();
        t_sci_level();
        t_route();
        t_polarity();
        t_gpi();
        t_wdt();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_900_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule